// File: doc/BRIEF.md
# MAC Source Address Learning Engine

This block keeps an associative table of 72-bit entries and learns station addresses from received packets. The ingress logic presents a packet descriptor: source and destination addresses, the ingress port number, an error flag and a control-frame flag. The engine then walks the whole table, one entry per clock. In the same pass it looks up the destination address and the source address, and it notes the first free slot.

When the walk ends, a known source address has its port field refreshed. An unknown source address is written into the first free slot. A packet marked as errored or as a control frame is not learned. The destination lookup result is reported for every packet, together with a flag that marks a packet whose source equals its destination; the forwarding logic drops such a packet.

A register-style port lets software write and read any entry while the engine is idle. The controller has three states:
- `ST_IDLE` waits for a descriptor. It moves to `ST_SCAN` when `pkt_valid` is seen.
- `ST_SCAN` reads one entry per cycle. It moves to `ST_COMMIT` after the last index.
- `ST_COMMIT` performs the single table write, or no write, and publishes the results. It always returns to `ST_IDLE`.

Top module: `addr_learn_engine`

## Requirements
- R1: After reset, `busy` and `res_valid` are low and every table entry reads as all zeros (entry type 00 = free).
- R2: A descriptor with `pkt_valid` high while `busy` is low is taken at that clock edge. `busy` is then high for exactly DEPTH+1 cycles. `res_valid` is high for one cycle, which is the first cycle in which `busy` is low again.
- R3: While `busy` is high, `pkt_valid` is ignored: no extra result appears and its source address is not learned.
- R4: Bit 40 (the group bit) of the source address is cleared before the search and before any write. A multicast source therefore matches, and is stored as, the unicast form of the same address.
- R5: A newly learned entry has the following layout, with every other bit zero:
  - address in bits 47:0;
  - entry type 01 (address) in bits 61:60;
  - unicast kind 11 in bits 63:62;
  - secure bit 64 = 0 and block bit 65 = 0;
  - ingress port in bits 66 upward, PORT_W bits wide.
- R6: A descriptor with `pkt_err` or `pkt_ctl` set leaves the table unchanged. The destination lookup is still reported for it.
- R7: When the normalised source address matches a type-01 entry (the lowest such index), only the port field of that entry is rewritten. All other bits are kept.
- R8: When there is no match, the new entry is written at the lowest index whose type is 00. If no such index exists, nothing is written.
- R9: Entries of type 10 or 11 are neither matched by address nor treated as free.
- R10: `dst_found` and `dst_port` report the lowest-index type-01 entry whose address equals the destination address. The lookup uses the table contents as they were before this packet's own write.
- R11: `pkt_self` is high when the normalised source address equals the destination address. Learning or updating still takes place for such a packet.
- R12: Software access happens only while `busy` is low and `sw_en` is high. A write (`sw_we`=1) stores `sw_wdata` at `sw_idx`. A read presents the entry on `sw_rdata` one cycle later, and `sw_rdata` holds its value otherwise. Requests made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Descriptor present |
| pkt_sa | input | 48 | Source address |
| pkt_da | input | 48 | Destination address |
| pkt_port | input | PORT_W | Ingress port number |
| pkt_err | input | 1 | Packet carries an error |
| pkt_ctl | input | 1 | Packet is a MAC control frame |
| busy | output | 1 | Search in progress; descriptors and software access are refused |
| res_valid | output | 1 | One-cycle pulse when results are updated |
| dst_found | output | 1 | Destination address found in the table |
| dst_port | output | PORT_W | Port of the matching destination entry |
| pkt_self | output | 1 | Source address equals destination address |
| sw_en | input | 1 | Software access request |
| sw_we | input | 1 | 1 = write, 0 = read |
| sw_idx | input | IDX_W | Entry index for software access |
| sw_wdata | input | 72 | Entry data to write |
| sw_rdata | output | 72 | Entry data read back |

## Verification
The engine's results appear DEPTH+1 clock edges after the edge that takes a descriptor, and a software read appears one edge after its request. The bench drives on falling edges and counts falling edges while `busy` is high. It checks that the count equals DEPTH+1, and samples the result outputs at the first falling edge on which `busy` is low, then confirms that `res_valid` has dropped one cycle later. After each group of packets, the table is read back entry by entry through the software port and compared against a model kept in the bench, built from the entry layout and the learning rules in the requirements.

// File: rtl/addr_learn_pkg.sv
package addr_learn_pkg;
    localparam int ENT_W     = 72;
    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;
    localparam int TYPE_LSB  = 60;
    localparam int UKIND_LSB = 62;
    localparam int SEC_BIT   = 64;
    localparam int BLK_BIT   = 65;
    localparam int PORT_LSB  = 66;

    typedef enum logic [1:0] {
        ET_FREE      = 2'b00,
        ET_ADDR      = 2'b01,
        ET_VLAN      = 2'b10,
        ET_ADDR_VLAN = 2'b11
    } ent_type_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2
    } lrn_state_e;
endpackage

// File: rtl/lrn_entry_match.sv
module lrn_entry_match
    import addr_learn_pkg::*;
(
    input  logic [MAC_W-1:0] e_addr,
    input  logic [1:0]       e_type,
    input  logic [MAC_W-1:0] key_sa,
    input  logic [MAC_W-1:0] key_da,
    output logic             is_free,
    output logic             sa_hit,
    output logic             da_hit
);
    logic is_addr;

    always_comb begin
        is_addr = (e_type == ET_ADDR);
        is_free = (e_type == ET_FREE);
        sa_hit  = is_addr && (e_addr == key_sa);
        da_hit  = is_addr && (e_addr == key_da);
    end
endmodule

// File: rtl/lrn_table.sv
module lrn_table
    import addr_learn_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int PORT_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_entry,
    input  logic             cw_en,
    input  logic             cw_upd,
    input  logic [IDX_W-1:0] cw_idx,
    input  logic [ENT_W-1:0] cw_data,
    input  logic             sw_go,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [ENT_W-1:0] sw_wdata,
    output logic [ENT_W-1:0] sw_rdata
);
    localparam logic [ENT_W-1:0] PORT_MASK =
        ((ENT_W'(1) << PORT_W) - ENT_W'(1)) << PORT_LSB;
    localparam logic [ENT_W-1:0] KEEP_MASK = ~PORT_MASK;

    logic [ENT_W-1:0] mem [DEPTH];

    assign rd_entry = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (cw_en) begin
            if (cw_upd) begin
                mem[cw_idx][PORT_LSB +: PORT_W] <= cw_data[PORT_LSB +: PORT_W];
            end else begin
                mem[cw_idx] <= cw_data;
            end
        end else if (sw_go && sw_we) begin
            mem[sw_idx] <= sw_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_rdata <= '0;
        end else if (sw_go && !sw_we) begin
            sw_rdata <= mem[sw_idx];
        end
    end

    // R12: software never shares a cycle with an engine write
    a_r12_sw_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        cw_en |-> !sw_go);

    // R7: an update keeps every bit outside the port field
    a_r7_port_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && cw_upd) |=> ((mem[$past(cw_idx)] & KEEP_MASK) ==
                               ($past(mem[cw_idx]) & KEEP_MASK)));

    // R8: a fresh entry only lands on a free slot
    a_r8_fill_free: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && !cw_upd) |-> (mem[cw_idx][TYPE_LSB +: 2] == ET_FREE));

    // R5: a fresh entry carries the learned control bits
    a_r5_new_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_en && !cw_upd) |-> (cw_data[TYPE_LSB +: 2] == ET_ADDR &&
                                cw_data[UKIND_LSB +: 2] == 2'b11 &&
                                !cw_data[SEC_BIT] && !cw_data[BLK_BIT]));
endmodule

// File: rtl/lrn_scan.sv
module lrn_scan
    import addr_learn_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int PORT_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [MAC_W-1:0]  pkt_sa,
    input  logic [MAC_W-1:0]  pkt_da,
    input  logic [PORT_W-1:0] pkt_port,
    input  logic              pkt_err,
    input  logic              pkt_ctl,
    output logic              busy,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [ENT_W-1:0]  rd_entry,
    output logic              cw_en,
    output logic              cw_upd,
    output logic [IDX_W-1:0]  cw_idx,
    output logic [ENT_W-1:0]  cw_data,
    output logic              res_valid,
    output logic              dst_found,
    output logic [PORT_W-1:0] dst_port,
    output logic              pkt_self
);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(DEPTH - 1);
    localparam logic [MAC_W-1:0] GROUP_MASK = MAC_W'(1) << GROUP_BIT;

    lrn_state_e state, nxt;

    logic [IDX_W-1:0]  idx;
    logic [MAC_W-1:0]  sa_q, da_q;
    logic [PORT_W-1:0] port_q;
    logic              learn_q;
    logic              hit_q, free_q, dh_q;
    logic [IDX_W-1:0]  hit_idx, free_idx;
    logic [PORT_W-1:0] dport_q;
    logic              m_free, m_sa, m_da;

    lrn_entry_match u_match (
        .e_addr  (rd_entry[MAC_W-1:0]),
        .e_type  (rd_entry[TYPE_LSB +: 2]),
        .key_sa  (sa_q),
        .key_da  (da_q),
        .is_free (m_free),
        .sa_hit  (m_sa),
        .da_hit  (m_da)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (pkt_valid) nxt = ST_SCAN;
            ST_SCAN:   if (idx == LAST_IDX) nxt = ST_COMMIT;
            ST_COMMIT: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // search datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            sa_q     <= '0;
            da_q     <= '0;
            port_q   <= '0;
            learn_q  <= 1'b0;
            hit_q    <= 1'b0;
            free_q   <= 1'b0;
            dh_q     <= 1'b0;
            hit_idx  <= '0;
            free_idx <= '0;
            dport_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pkt_valid) begin
                        sa_q     <= pkt_sa & ~GROUP_MASK;
                        da_q     <= pkt_da;
                        port_q   <= pkt_port;
                        learn_q  <= !(pkt_err || pkt_ctl);
                        idx      <= '0;
                        hit_q    <= 1'b0;
                        free_q   <= 1'b0;
                        dh_q     <= 1'b0;
                        hit_idx  <= '0;
                        free_idx <= '0;
                        dport_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    idx <= idx + 1'b1;
                    if (m_sa && !hit_q) begin
                        hit_q   <= 1'b1;
                        hit_idx <= idx;
                    end
                    if (m_free && !free_q) begin
                        free_q   <= 1'b1;
                        free_idx <= idx;
                    end
                    if (m_da && !dh_q) begin
                        dh_q    <= 1'b1;
                        dport_q <= rd_entry[PORT_LSB +: PORT_W];
                    end
                end
                default: ;
            endcase
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            dst_found <= 1'b0;
            dst_port  <= '0;
            pkt_self  <= 1'b0;
        end else begin
            res_valid <= (state == ST_COMMIT);
            if (state == ST_COMMIT) begin
                dst_found <= dh_q;
                dst_port  <= dport_q;
                pkt_self  <= (sa_q == da_q);
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        rd_idx  = idx;
        cw_en   = (state == ST_COMMIT) && learn_q && (hit_q || free_q);
        cw_upd  = hit_q;
        cw_idx  = hit_q ? hit_idx : free_idx;
        cw_data = '0;
        cw_data[MAC_W-1:0]            = sa_q;
        cw_data[TYPE_LSB +: 2]        = ET_ADDR;
        cw_data[UKIND_LSB +: 2]       = 2'b11;
        cw_data[PORT_LSB +: PORT_W]   = port_q;
    end

    // R4: the held source key never has the group bit
    a_r4_group_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !sa_q[GROUP_BIT]);

    // R3: the descriptor is frozen while searching
    a_r3_desc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |=> ($stable(sa_q) && $stable(da_q) && $stable(port_q)));

    // R2: results only follow the commit step
    a_r2_res_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(state) == ST_COMMIT && !busy));

    // R6: no write is issued for refused frames
    a_r6_no_learn_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && !learn_q) |-> !cw_en);
endmodule

// File: rtl/addr_learn_engine.sv
module addr_learn_engine
    import addr_learn_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int PORT_W = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [47:0]       pkt_sa,
    input  logic [47:0]       pkt_da,
    input  logic [PORT_W-1:0] pkt_port,
    input  logic              pkt_err,
    input  logic              pkt_ctl,
    output logic              busy,
    output logic              res_valid,
    output logic              dst_found,
    output logic [PORT_W-1:0] dst_port,
    output logic              pkt_self,
    input  logic              sw_en,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [71:0]       sw_wdata,
    output logic [71:0]       sw_rdata
);
    logic [IDX_W-1:0] rd_idx, cw_idx;
    logic [ENT_W-1:0] rd_entry, cw_data;
    logic             cw_en, cw_upd, sw_go;

    assign sw_go = sw_en && !busy;

    lrn_scan #(.DEPTH(DEPTH), .PORT_W(PORT_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .pkt_sa    (pkt_sa),
        .pkt_da    (pkt_da),
        .pkt_port  (pkt_port),
        .pkt_err   (pkt_err),
        .pkt_ctl   (pkt_ctl),
        .busy      (busy),
        .rd_idx    (rd_idx),
        .rd_entry  (rd_entry),
        .cw_en     (cw_en),
        .cw_upd    (cw_upd),
        .cw_idx    (cw_idx),
        .cw_data   (cw_data),
        .res_valid (res_valid),
        .dst_found (dst_found),
        .dst_port  (dst_port),
        .pkt_self  (pkt_self)
    );

    lrn_table #(.DEPTH(DEPTH), .PORT_W(PORT_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_entry (rd_entry),
        .cw_en    (cw_en),
        .cw_upd   (cw_upd),
        .cw_idx   (cw_idx),
        .cw_data  (cw_data),
        .sw_go    (sw_go),
        .sw_we    (sw_we),
        .sw_idx   (sw_idx),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata)
    );
endmodule

// File: tb/addr_learn_engine_test.sv
module addr_learn_engine_test;
    localparam int DEPTH  = 8;
    localparam int PORT_W = 2;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pkt_valid = 1'b0;
    logic [47:0]       pkt_sa = '0, pkt_da = '0;
    logic [PORT_W-1:0] pkt_port = '0;
    logic              pkt_err = 1'b0, pkt_ctl = 1'b0;
    logic              busy, res_valid, dst_found, pkt_self;
    logic [PORT_W-1:0] dst_port;
    logic              sw_en = 1'b0, sw_we = 1'b0;
    logic [IDX_W-1:0]  sw_idx = '0;
    logic [71:0]       sw_wdata = '0, sw_rdata;

    int n_chk = 0, n_fail = 0;

    logic [71:0] exp_tab [DEPTH];
    logic        exp_found, exp_self;
    logic [1:0]  exp_dport;

    always #2 clk = ~clk;

    addr_learn_engine #(.DEPTH(DEPTH), .PORT_W(PORT_W)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_sa(pkt_sa),
        .pkt_da(pkt_da), .pkt_port(pkt_port), .pkt_err(pkt_err), .pkt_ctl(pkt_ctl),
        .busy(busy), .res_valid(res_valid), .dst_found(dst_found),
        .dst_port(dst_port), .pkt_self(pkt_self), .sw_en(sw_en), .sw_we(sw_we),
        .sw_idx(sw_idx), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
    );

    function automatic logic [71:0] mk(input logic [47:0] a, input logic [1:0] t,
                                       input logic [1:0] k, input logic sec,
                                       input logic blk, input logic [1:0] p);
        logic [71:0] e = '0;
        e[47:0] = a; e[61:60] = t; e[63:62] = k; e[64] = sec; e[65] = blk;
        e[67:66] = p;
        return e;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic sw_write(input int i, input logic [71:0] d);
        @(negedge clk);
        sw_en = 1'b1; sw_we = 1'b1; sw_idx = IDX_W'(i); sw_wdata = d;
        @(negedge clk);
        sw_en = 1'b0; sw_we = 1'b0;
        exp_tab[i] = d;
    endtask

    task automatic sw_read(input int i, output logic [71:0] d);
        @(negedge clk);
        sw_en = 1'b1; sw_we = 1'b0; sw_idx = IDX_W'(i);
        @(negedge clk);
        d = sw_rdata;
        sw_en = 1'b0;
    endtask

    task automatic check_table(input string req);
        logic [71:0] d;
        for (int i = 0; i < DEPTH; i++) begin
            sw_read(i, d);
            chk(req, $sformatf("entry %0d", i), d, exp_tab[i]);
        end
    endtask

    // expected outcome from the learning rules
    task automatic model_step(input logic [47:0] sa, input logic [47:0] da,
                              input logic [1:0] p, input logic refuse);
        logic [47:0] nsa;
        int hit, fre;
        nsa = sa & ~(48'h1 << 40);
        exp_found = 1'b0; exp_dport = '0; hit = -1; fre = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (exp_tab[i][61:60] == 2'b01 && exp_tab[i][47:0] == da && !exp_found) begin
                exp_found = 1'b1; exp_dport = exp_tab[i][67:66];
            end
            if (exp_tab[i][61:60] == 2'b01 && exp_tab[i][47:0] == nsa && hit < 0) hit = i;
            if (exp_tab[i][61:60] == 2'b00 && fre < 0) fre = i;
        end
        exp_self = (nsa == da);
        if (!refuse) begin
            if (hit >= 0) exp_tab[hit][67:66] = p;
            else if (fre >= 0) exp_tab[fre] = mk(nsa, 2'b01, 2'b11, 1'b0, 1'b0, p);
        end
    endtask

    task automatic send(input logic [47:0] sa, input logic [47:0] da, input logic [1:0] p,
                        input logic err, input logic ctl, input logic ghost,
                        input string req);
        int cnt;
        model_step(sa, da, p, err | ctl);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_sa = sa; pkt_da = da; pkt_port = p;
        pkt_err = err; pkt_ctl = ctl;
        @(negedge clk);
        pkt_valid = 1'b0; pkt_err = 1'b0; pkt_ctl = 1'b0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            if (ghost && cnt <= 3) begin
                // R3 / R12: refused traffic while busy
                pkt_valid = 1'b1; pkt_sa = 48'h0200_0000_0F0F; pkt_port = 2'd1;
                sw_en = 1'b1; sw_we = 1'b1; sw_idx = 3'd7; sw_wdata = {72{1'b1}};
            end else begin
                pkt_valid = 1'b0; sw_en = 1'b0; sw_we = 1'b0;
            end
            @(negedge clk);
        end
        pkt_valid = 1'b0; sw_en = 1'b0; sw_we = 1'b0;
        chk("R2", "busy length", 72'(cnt), 72'(DEPTH + 1));
        chk("R2", "res_valid pulse", 72'(res_valid), 72'(1));
        chk({req, "/R10"}, "dst_found", 72'(dst_found), 72'(exp_found));
        if (exp_found) chk({req, "/R10"}, "dst_port", 72'(dst_port), 72'(exp_dport));
        chk({req, "/R11"}, "pkt_self", 72'(pkt_self), 72'(exp_self));
        @(negedge clk);
        chk("R2", "res_valid drop", 72'(res_valid), 72'(0));
        if (ghost) chk("R3", "no second result", 72'(busy | res_valid), 72'(0));
    endtask

    localparam logic [47:0] A = 48'h0200_0000_0A01;
    localparam logic [47:0] B = 48'h0200_0000_0B02;
    localparam logic [47:0] C = 48'h0200_0000_0C03;
    localparam logic [47:0] D = 48'h0200_0000_0D04;
    localparam logic [47:0] E = 48'h0200_0000_0E05;
    localparam logic [47:0] F = 48'h0200_0000_0F06;
    localparam logic [47:0] H = 48'h0200_0000_1107;
    localparam logic [47:0] J = 48'h0200_0000_2208;
    localparam logic [47:0] K = 48'h0200_0000_3309;
    localparam logic [47:0] Z = 48'h0200_0000_9999;
    localparam logic [47:0] GB = 48'h0100_0000_0000;

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_tab[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", 72'(busy), 72'(0));
        chk("R1", "res_valid", 72'(res_valid), 72'(0));
        check_table("R1");

        send(A, Z, 2'd1, 1'b0, 1'b0, 1'b0, "R8");
        check_table("R5");
        send(B, A, 2'd2, 1'b0, 1'b0, 1'b0, "R10");
        sw_write(2, mk(C, 2'b01, 2'b00, 1'b1, 1'b1, 2'd0));
        send(C, B, 2'd3, 1'b0, 1'b0, 1'b0, "R7");
        check_table("R7");
        send(A | GB, C, 2'd0, 1'b0, 1'b0, 1'b0, "R4");
        send(D | GB, A, 2'd1, 1'b0, 1'b0, 1'b0, "R4");
        check_table("R4");
        send(E, A, 2'd2, 1'b1, 1'b0, 1'b0, "R6");
        send(E, A, 2'd2, 1'b0, 1'b1, 1'b0, "R6");
        check_table("R6");
        send(F, A, 2'd3, 1'b0, 1'b0, 1'b1, "R3");
        check_table("R12");
        sw_write(5, mk(H, 2'b10, 2'b00, 1'b0, 1'b0, 2'd0));
        send(H, H, 2'd1, 1'b0, 1'b0, 1'b0, "R11");
        send(H, H, 2'd2, 1'b0, 1'b0, 1'b0, "R11");
        check_table("R9");
        sw_write(7, mk(J, 2'b11, 2'b00, 1'b0, 1'b0, 2'd1));
        send(K, A, 2'd3, 1'b0, 1'b0, 1'b0, "R8");
        send(J, J, 2'd2, 1'b0, 1'b0, 1'b0, "R9");
        check_table("R8");

        // sweep over ports and a rotating address set
        for (int i = 0; i < DEPTH; i++) sw_write(i, '0);
        check_table("R12");
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 6; a++) begin
                send(48'h0200_00AB_0000 + 48'(a) + (((a + p) % 3 == 0) ? GB : 48'h0),
                     48'h0200_00AB_0000 + 48'((a + 1) % 6), 2'(p),
                     ((a + p) % 5 == 0), 1'b0, 1'b0, "R8");
            end
            check_table("R7");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule